// File: doc/BRIEF.md
# Lock-Gated System Reset Sequencer

This block generates the system reset for a synchronous design whose clocks all come from one clock manager. It keeps reset asserted while the clock manager reports no lock. Once lock is present, it releases reset only after lock has held for a set number of consecutive cycles. An active-high external reset request passes through a two-flop synchronizer and a debounce filter before it can start a new reset sequence.

Reset is asserted asynchronously: loss of lock, or an external request that the debounce filter has accepted, raises it at once. Reset is released only on a rising edge of the main clock, through a two-stage output synchronizer. This gives downstream logic a fixed, known start-up latency. A per-domain copy of the reset is registered from the global reset, so that skew on the high-fanout net does no harm. A status output is high while the sequencer waits for lock to stay stable.

Top module: `lock_reset_seq`

With the defaults DEB = DEBOUNCE_CYCLES = 16 and LCK = LOCK_STABLE_CYCLES = 8, the release latency is L = DEB + LCK + 4 = 28 rising edges.

## Requirements
- R1: While `lock` is low, `sys_rst` and `dom_rst` are 1 and `lock_wait` is 0. This includes power-up.
- R2: A falling `lock` sets `sys_rst` and `dom_rst` to 1 at once, without waiting for a clock edge.
- R3: Take `lock` high and keep `ext_rst_req` at 0. Count rising edges from the first edge after `lock` rises. `sys_rst` stays 1 through edge L-1 and is 0 after edge L. Any low period on `lock` restarts the count.
- R4: Counting edges as in R3, `lock_wait` is 1 from edge DEB+2 through edge DEB+LCK+1, and 0 at all other times.
- R5: `dom_rst` becomes 1 whenever `sys_rst` does. It returns to 0 exactly DOMAIN_STAGES edges after `sys_rst` falls.
- R6: A high pulse on `ext_rst_req` that is seen by fewer than DEB consecutive rising edges leaves `sys_rst` at 0.
- R7: If `ext_rst_req` is 1 for DEB or more consecutive edges, count from the first edge that samples it high. `sys_rst` is 0 after edge DEB+1 and 1 after edge DEB+2, and `lock_wait` is then 0.
- R8: After an accepted request, count from the first edge that samples `ext_rst_req` low. `sys_rst` is 1 after edge L-1 and 0 after edge L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| ext_rst_req | input | 1 | Asynchronous external reset request, active-high |
| lock | input | 1 | Clock-manager lock indicator |
| sys_rst | output | 1 | Global system reset, active-high |
| dom_rst | output | 1 | Locally registered per-domain reset, active-high |
| lock_wait | output | 1 | High while waiting for lock to stay stable |

## Verification
A debounce counter that is off by one turns the boundary pulse into the wrong outcome. A pulse of exactly DEB cycles would then be ignored, or one of DEB-1 cycles accepted, and `sys_rst` would show the error within DEB+2 edges. A lock-stable counter that does not restart, or a stage added or missing in the release path, moves the falling edge of `sys_rst` or `lock_wait` away from its exact expected cycle. A missing asynchronous preset is seen one time step after `lock` falls, before any clock edge.

// File: rtl/lock_reset_seq.sv
module lock_reset_seq #(
  parameter int DEBOUNCE_CYCLES    = 16,
  parameter int LOCK_STABLE_CYCLES = 8,
  parameter int DOMAIN_STAGES      = 2
) (
  input  logic clk,
  input  logic ext_rst_req,
  input  logic lock,
  output logic sys_rst,
  output logic dom_rst,
  output logic lock_wait
);
  localparam int DW = $clog2(DEBOUNCE_CYCLES + 1);
  localparam int LW = $clog2(LOCK_STABLE_CYCLES + 1);

  logic                     lock_lost;
  logic [1:0]               ext_sync;
  logic                     ext_s;
  logic                     ext_held;
  logic [DW-1:0]            deb_cnt;
  logic [LW-1:0]            lock_cnt;
  logic                     stable;
  logic                     hold_rst;
  logic                     out_arst;
  logic [1:0]               rel_q;
  logic [DOMAIN_STAGES-1:0] dom_q;

  assign lock_lost = ~lock;
  assign ext_s     = ext_sync[1];

  always_ff @(posedge clk or posedge lock_lost)
    if (lock_lost) ext_sync <= 2'b11;
    else           ext_sync <= {ext_sync[0], ext_rst_req};

  always_ff @(posedge clk or posedge lock_lost)
    if (lock_lost) begin
      ext_held <= 1'b1;
      deb_cnt  <= '0;
    end else if (ext_s == ext_held) begin
      deb_cnt  <= '0;
    end else if (deb_cnt == DW'(DEBOUNCE_CYCLES - 1)) begin
      ext_held <= ext_s;
      deb_cnt  <= '0;
    end else begin
      deb_cnt  <= deb_cnt + 1'b1;
    end

  always_ff @(posedge clk or posedge lock_lost)
    if (lock_lost) begin
      lock_cnt <= '0;
      stable   <= 1'b0;
    end else if (ext_held) begin
      lock_cnt <= '0;
      stable   <= 1'b0;
    end else if (!stable) begin
      if (lock_cnt == LW'(LOCK_STABLE_CYCLES - 1)) stable <= 1'b1;
      else                                         lock_cnt <= lock_cnt + 1'b1;
    end

  assign hold_rst  = ext_held | ~stable;
  assign out_arst  = lock_lost | ext_held;
  assign lock_wait = ~ext_held & ~stable;

  always_ff @(posedge clk or posedge out_arst)
    if (out_arst) rel_q <= 2'b11;
    else          rel_q <= {rel_q[0], hold_rst};

  assign sys_rst = rel_q[1];

  always_ff @(posedge clk or posedge sys_rst)
    if (sys_rst) dom_q <= '1;
    else         dom_q <= dom_q << 1;

  assign dom_rst = dom_q[DOMAIN_STAGES-1];

  // R1 R2
  always @(negedge clk)
    if (!lock) lock_low_chk: assert (sys_rst && dom_rst && !lock_wait);

  // R3
  lock_cnt_range_chk: assert property (@(posedge clk) disable iff (!lock)
    lock_cnt < LW'(LOCK_STABLE_CYCLES));

  // R3
  release_after_stable_chk: assert property (@(posedge clk) disable iff (!lock)
    $fell(sys_rst) |-> $past(stable));

  // R4
  wait_in_reset_chk: assert property (@(posedge clk) disable iff (!lock)
    lock_wait |-> sys_rst);

  // R5
  dom_follow_chk: assert property (@(posedge clk) disable iff (!lock)
    sys_rst |-> dom_rst);
endmodule

// File: tb/tb_lock_reset_seq.sv
module tb_lock_reset_seq;
  localparam int DEB = 16;
  localparam int LCK = 8;
  localparam int DS  = 2;

  logic clk = 1'b0;
  logic ext_rst_req = 1'b0;
  logic lock = 1'b0;
  logic sys_rst, dom_rst, lock_wait;
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;

  always #10 clk = ~clk;

  lock_reset_seq #(.DEBOUNCE_CYCLES(DEB), .LOCK_STABLE_CYCLES(LCK), .DOMAIN_STAGES(DS)) dut (
    .clk(clk), .ext_rst_req(ext_rst_req), .lock(lock),
    .sys_rst(sys_rst), .dom_rst(dom_rst), .lock_wait(lock_wait));

  function automatic int rel_lat();
    return DEB + LCK + 4;
  endfunction

  function automatic bit pulse_taken(int len);
    return len >= DEB;
  endfunction

  function automatic bit wait_expected(int e);
    return (e >= DEB + 2) && (e <= DEB + LCK + 1);
  endfunction

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, logic act, logic exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic lock_up_and_release();
    lock = 1'b1;
    for (int e = 1; e <= rel_lat() + DS; e++) begin
      tick(1);
      if (e == DEB + 1 || e == DEB + 2 || e == DEB + LCK + 1 || e == DEB + LCK + 2)
        chk("R4", lock_wait, wait_expected(e), "lock_wait");
      if (e == rel_lat() - 1) chk("R3", sys_rst, 1'b1, "sys_rst before release");
      if (e == rel_lat())     chk("R3", sys_rst, 1'b0, "sys_rst at release");
      if (e == rel_lat() + DS - 1) chk("R5", dom_rst, 1'b1, "dom_rst before release");
      if (e == rel_lat() + DS)     chk("R5", dom_rst, 1'b0, "dom_rst at release");
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    tick(5);
    chk("R1", sys_rst, 1'b1, "sys_rst power-up");
    chk("R1", dom_rst, 1'b1, "dom_rst power-up");
    chk("R1", lock_wait, 1'b0, "lock_wait power-up");

    lock_up_and_release();

    // R2: lock loss asserts without a clock edge
    for (int k = 0; k < 3; k++) begin
      tick(1 + ($urandom % 7));
      #3 lock = 1'b0;
      #1;
      chk("R2", sys_rst, 1'b1, "sys_rst on lock loss");
      chk("R2", dom_rst, 1'b1, "dom_rst on lock loss");
      tick(1);
      lock_up_and_release();
    end

    // R3: lock drop during the wait restarts the count
    for (int k = 0; k < 4; k++) begin
      lock = 1'b0;
      tick(2);
      lock = 1'b1;
      tick(1 + ($urandom % (rel_lat() - 2)));
      chk("R3", sys_rst, 1'b1, "sys_rst mid-wait");
      lock = 1'b0;
      tick(1 + ($urandom % 3));
      lock_up_and_release();
    end

    // R6 / R7: pulses around the debounce boundary, then random ones
    for (int k = 0; k < 10; k++) begin
      int len;
      bit ignored_ok;
      if (k == 0)      len = DEB - 1;
      else if (k == 1) len = DEB;
      else             len = 1 + ($urandom % (DEB + 20));
      ignored_ok = 1'b1;
      for (int e = 1; e <= len + rel_lat() + 4; e++) begin
        ext_rst_req = (e <= len);
        tick(1);
        if (pulse_taken(len)) begin
          if (e == DEB + 1) chk("R7", sys_rst, 1'b0, "sys_rst before accept");
          if (e == DEB + 2) begin
            chk("R7", sys_rst, 1'b1, "sys_rst on accept");
            chk("R7", lock_wait, 1'b0, "lock_wait during request");
          end
          if (e == len + rel_lat() - 1) chk("R8", sys_rst, 1'b1, "sys_rst before release");
          if (e == len + rel_lat())     chk("R8", sys_rst, 1'b0, "sys_rst at release");
        end else if (sys_rst !== 1'b0) begin
          ignored_ok = 1'b0;
        end
      end
      if (!pulse_taken(len)) chk("R6", ~ignored_ok, 1'b0, "short pulse caused reset");
      ext_rst_req = 1'b0;
      tick(DS + 2);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule